// File: doc/BRIEF.md
# Buffered Four-Phase Peripheral Write Link

This block carries host writes out to a slower or unrelated peripheral. Host words enter through a valid/ready port and queue in a small first-in first-out buffer. This buffer lets the host run ahead of the peripheral.

For each queued word, the link raises a request and waits for the peripheral's first acknowledge, which grants permission. Only then does it drive the word onto a parallel data bus and raise a data strobe. It then waits for a second acknowledge, which confirms receipt. That second acknowledge retires the word and ends the transfer.

Both acknowledges arrive on one line that must return low between phases. The line is asynchronous to the module clock, so it passes through a two-stage synchroniser before the control logic uses it.

Top module: `wr_handshake_link`

## Requirements
- R1: While reset is held, `req_o` and `send_o` are 0 and `in_ready` is 1.
- R2: `req_o` rises only when the buffer holds at least one word and the acknowledge line has been seen low since the previous transfer. With an empty buffer, `req_o` stays 0.
- R3: When the synchronised acknowledge is seen high during a request, the link does three things in the same cycle: it drops `req_o`, it loads the head word onto `pdata_o`, and it keeps `send_o` at 0.
- R4: `send_o` rises only after the synchronised acknowledge has returned low following the grant. It stays 0 for as long as the acknowledge is held high.
- R5: `pdata_o` holds the same value from the grant until the receipt acknowledge ends the transfer.
- R6: A receipt acknowledge seen while `send_o` is 1 does two things: it drops `send_o` and it removes the word from the buffer. No new request starts until the acknowledge line is back low.
- R7: The buffer holds `DEPTH` words (default 4). `in_ready` is 0 when it is full, and a write offered while it is full is not stored.
- R8: Words reach `pdata_o` in the order the host wrote them.
- R9: An edge on `ack_i` affects the outputs exactly three clock edges after it is applied: two synchroniser stages plus the registered control output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a word |
| in_ready | output | 1 | Buffer can take a word |
| in_data | input | DW | Host write word |
| req_o | output | 1 | Permission request to the peripheral |
| ack_i | input | 1 | Peripheral acknowledge (asynchronous), used for both grant and receipt |
| send_o | output | 1 | Data present on `pdata_o` |
| pdata_o | output | DW | Parallel data bus to the peripheral |

## Verification
Every change on `ack_i` shows up on `req_o` or `send_o` exactly three rising edges later. The bench drives `ack_i` on a falling edge and samples on the falling edge after the third rising edge. It also samples after the second rising edge to confirm that nothing has moved yet.

A host write reaches `in_ready` one edge after it is accepted, and `in_ready` is sampled before each write. The data checks run at the grant edge and again after each programmed hold interval.

The sweep covers every buffer fill level from one word up to two writes past full. For each word, the expected data is computed from the sweep index and the word index.

// File: rtl/wr_handshake_link.sv
module wr_handshake_link #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          req_o,
  input  logic          ack_i,
  output logic          send_o,
  output logic [DW-1:0] pdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {IDLE, ASK, HOLD, XFER, DRAIN} st_t;
  st_t st;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] count;
  logic          ack_m, ack_s;
  logic          push, pop;

  assign in_ready = (count < CW'(DEPTH));
  assign push     = in_valid && in_ready;
  assign pop      = (st == XFER) && ack_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= ack_i;
      ack_s <= ack_m;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (push) wr_idx <= (wr_idx == AW'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;
      if (pop)  rd_idx <= (rd_idx == AW'(DEPTH - 1)) ? '0 : rd_idx + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      req_o   <= 1'b0;
      send_o  <= 1'b0;
      pdata_o <= '0;
    end else begin
      unique case (st)
        IDLE:  if (count != '0) begin req_o <= 1'b1; st <= ASK; end
        ASK:   if (ack_s) begin
                 req_o   <= 1'b0;
                 pdata_o <= mem[rd_idx];
                 st      <= HOLD;
               end
        HOLD:  if (!ack_s) begin send_o <= 1'b1; st <= XFER; end
        XFER:  if (ack_s) begin send_o <= 1'b0; st <= DRAIN; end
        DRAIN: if (!ack_s) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  // R2
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> ($past(count) != '0 && !$past(ack_s)));
  // R3
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> ($past(ack_s) && !send_o));
  // R4
  send_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_o) |-> !$past(ack_s));
  // R5
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_o |-> $stable(pdata_o));
  // R6
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_o && send_o));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: tb/wr_handshake_link_bench.sv
module wr_handshake_link_bench;
  localparam int DW = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic ack_i = 1'b0;
  logic in_ready, req_o, send_o;
  logic [DW-1:0] pdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wr_handshake_link #(.DW(DW), .DEPTH(DEPTH)) u_wr_handshake_link (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .req_o(req_o), .ack_i(ack_i), .send_o(send_o),
    .pdata_o(pdata_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic serve(input logic [DW-1:0] exp, input int hold);
    int w = 0;
    while (!req_o && w < 60) begin step(1); w++; end
    chk(req_o == 1'b1, "R2 request for queued word", int'(req_o), 1);
    chk(send_o == 1'b0, "R3 no data strobe during request", int'(send_o), 0);
    ack_i = 1'b1;
    step(2);
    chk(req_o == 1'b1, "R9 request held two edges after grant", int'(req_o), 1);
    step(1);
    chk(req_o == 1'b0, "R3 request dropped on grant", int'(req_o), 0);
    chk(send_o == 1'b0, "R3 strobe low at grant", int'(send_o), 0);
    chk(pdata_o == exp, "R8 word order", int'(pdata_o), int'(exp));
    step(hold + 1);
    chk(send_o == 1'b0, "R4 strobe waits for ack low", int'(send_o), 0);
    ack_i = 1'b0;
    step(2);
    chk(send_o == 1'b0, "R9 strobe still low two edges after ack low", int'(send_o), 0);
    step(1);
    chk(send_o == 1'b1, "R4 strobe raised after ack low", int'(send_o), 1);
    chk(pdata_o == exp, "R5 data held at strobe", int'(pdata_o), int'(exp));
    step(hold);
    chk(pdata_o == exp, "R5 data held during strobe", int'(pdata_o), int'(exp));
    ack_i = 1'b1;
    step(3);
    chk(send_o == 1'b0, "R6 strobe dropped on receipt", int'(send_o), 0);
    step(hold + 1);
    chk(req_o == 1'b0, "R6 no request while ack high", int'(req_o), 0);
    ack_i = 1'b0;
    step(3);
    chk(req_o == 1'b0, "R6 no request before idle", int'(req_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk(req_o == 1'b0, "R1 reset request", int'(req_o), 0);
    chk(send_o == 1'b0, "R1 reset strobe", int'(send_o), 0);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    rst_n = 1'b1;
    step(10);
    chk(req_o == 1'b0, "R2 empty buffer stays idle", int'(req_o), 0);

    for (int n = 1; n <= DEPTH + 2; n++) begin
      for (int k = 0; k < n; k++) begin
        chk(in_ready == (k < DEPTH), "R7 ready follows fill level",
            int'(in_ready), int'(k < DEPTH));
        in_valid = 1'b1;
        in_data = DW'(n * 16 + k);
        step(1);
      end
      in_valid = 1'b0;
      for (int k = 0; k < n && k < DEPTH; k++)
        serve(DW'(n * 16 + k), (n + k) % 3);
      step(12);
      chk(req_o == 1'b0, "R7 write while full not stored", int'(req_o), 0);
      chk(in_ready == 1'b1, "R6 drained buffer ready", int'(in_ready), 1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule